// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is an up/down timer that produces centre-aligned pulse-width-modulated waveforms on two compare channels, A and B. The counter climbs from zero to a ceiling, turns round, falls back to zero and repeats. Because each transition lies the same distance from the ceiling on the rising and falling slopes, every pulse is centred in its period. This suits motor and power-stage drive.

The ceiling is either the full-scale count or the active compare value of channel A. Compare values are written into holding registers. They reach the comparators only when the counter sits at its ceiling, so a period never mixes old and new values. Each channel has a 2-bit output-mode field that selects one of three behaviours:
- the output is held low;
- the output is cleared while rising and set while falling;
- the opposite of that.

An external prescaler supplies the count-enable strobe. Sticky flags mark overflow, which is the return to zero, and compare matches.

Top module: `pwm_phase_correct`

## Requirements
- R1: While `rst` is high and after it falls, `count` is 0 and the direction is up. `wave_a`, `wave_b`, `ovf_flag`, `match_a_flag` and `match_b_flag` are 0. Both holding and active compare values are 0.
- R2: On each clock with `tick` high, the counter does the following. Rising below the ceiling, it adds one. At or above the ceiling while rising, it turns to falling and subtracts one, or stays at 0 if the ceiling is 0. Falling, it subtracts one, and on reaching 0 it turns to rising. The ceiling value and the zero value therefore each last exactly one tick.
- R3: With `top_sel` = 0 the ceiling is 255 (all ones). With `top_sel` = 1 the ceiling is channel A's active compare value.
- R4: A high `cmp_a_we` or `cmp_b_we` loads `cmp_a_in` or `cmp_b_in` into that channel's holding register at the clock edge. The active compare values copy the holding registers only on a tick on which the counter is rising and at or above the ceiling.
- R5: `mode_x` = 2 (non-inverting): on a tick where `count` equals the channel's active compare value, the output goes to 0 if the direction is up and to 1 if it is down. The direction is up on both the zero tick and the ceiling tick.
- R6: `mode_x` = 3 (inverting): on a compare-match tick, the output goes to 1 if the direction is up and to 0 if it is down.
- R7: `mode_x` = 0 or 1 drives that channel's output to 0 at the next clock edge, whether or not `tick` is high.
- R8: `ovf_flag` is set by the tick on which the falling counter reaches 0, so it rises together with `count` becoming 0. It is cleared by a high `ovf_clr`, and setting wins over clearing.
- R9: `match_x_flag` is set by a tick on which `count` equals that channel's active compare value. It is cleared by a high `match_x_clr`, and setting wins over clearing.
- R10: On clocks with `tick` low, `count`, the direction, the active compare values and the output levels stay unchanged. The exceptions are the forced low of R7, flag clears and holding-register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable strobe from the prescaler |
| top_sel | input | 1 | Ceiling select: 0 = full scale, 1 = channel A compare |
| cmp_a_we | input | 1 | Write strobe for channel A holding register |
| cmp_a_in | input | 8 | Channel A compare value to hold |
| cmp_b_we | input | 1 | Write strobe for channel B holding register |
| cmp_b_in | input | 8 | Channel B compare value to hold |
| mode_a | input | 2 | Channel A output mode (0/1 off, 2 non-inverting, 3 inverting) |
| mode_b | input | 2 | Channel B output mode |
| ovf_clr | input | 1 | Clear overflow flag |
| match_a_clr | input | 1 | Clear channel A match flag |
| match_b_clr | input | 1 | Clear channel B match flag |
| count | output | 8 | Current counter value |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_a_flag | output | 1 | Sticky channel A match flag |
| match_b_flag | output | 1 | Sticky channel B match flag |

## Verification
The assertions treat `tick` as a plain level that is sampled on every clock. They also assume that every input is stable and known across a clock edge. The step-size check further assumes the ceiling never drops below zero.

To keep within these assumptions, the stimulus changes inputs only on the falling clock edge and leaves the design in reset for several cycles. It uses ceilings of 255, 100, 60, 40 and 80, so that the counter is sometimes above a newly lowered ceiling and has to turn round at once. Strobe densities range from every cycle down to about one in three, with a stretch of no strobes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    CMO_OFF     = 2'd0,
    CMO_OFF_ALT = 2'd1,
    CMO_NONINV  = 2'd2,
    CMO_INV     = 2'd3
  } cmo_mode_e;

  function automatic logic cmo_enabled(input cmo_mode_e m);
    return (m == CMO_NONINV) || (m == CMO_INV);
  endfunction

endpackage

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] ceil_val,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         rising,
  output logic         at_ceil,
  output logic         ovf_flag
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic hit_bottom;

  always_comb begin
    at_ceil    = rising && (cnt >= ceil_val);
    hit_bottom = !rising && (cnt <= ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= ZERO;
      rising <= 1'b1;
    end else if (tick) begin
      if (rising) begin
        if (at_ceil) begin
          rising <= 1'b0;
          cnt    <= (cnt == ZERO) ? ZERO : cnt - ONE;
        end else begin
          cnt <= cnt + ONE;
        end
      end else if (hit_bottom) begin
        rising <= 1'b1;
        cnt    <= ZERO;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     ovf_flag <= 1'b0;
    else if (tick && hit_bottom) ovf_flag <= 1'b1;
    else if (ovf_clr)            ovf_flag <= 1'b0;
  end

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt) && $stable(rising));

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE) || (cnt == $past(cnt)));

  // R8
  ovf_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> (cnt == ZERO));

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         reload,
  input  logic [W-1:0] cnt,
  input  logic         rising,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  cmo_mode_e    mode,
  input  logic         flag_clr,
  output logic [W-1:0] active,
  output logic         wave,
  output logic         flag
);
  logic [W-1:0] hold_q;
  logic         hit;

  always_comb hit = (cnt == active);

  always_ff @(posedge clk) begin
    if (rst)        hold_q <= '0;
    else if (wr_en) hold_q <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (rst)                 active <= '0;
    else if (tick && reload) active <= hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst)              flag <= 1'b0;
    else if (tick && hit) flag <= 1'b1;
    else if (flag_clr)    flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                    wave <= 1'b0;
    else if (!cmo_enabled(mode)) wave <= 1'b0;
    else if (tick && hit)        wave <= (mode == CMO_INV) ? rising : !rising;
  end

  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cmo_enabled(mode) |=> !wave);

  // R9
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick && hit));

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick && reload) |=> $stable(active));

  // R10
  wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && cmo_enabled(mode)) |=> $stable(wave));

endmodule

// File: rtl/pwm_phase_correct.sv
module pwm_phase_correct
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         top_sel,
  input  logic         cmp_a_we,
  input  logic [W-1:0] cmp_a_in,
  input  logic         cmp_b_we,
  input  logic [W-1:0] cmp_b_in,
  input  logic [1:0]   mode_a,
  input  logic [1:0]   mode_b,
  input  logic         ovf_clr,
  input  logic         match_a_clr,
  input  logic         match_b_clr,
  output logic [W-1:0] count,
  output logic         wave_a,
  output logic         wave_b,
  output logic         ovf_flag,
  output logic         match_a_flag,
  output logic         match_b_flag
);
  localparam int           NCH  = 2;
  localparam logic [W-1:0] FULL = '1;

  logic         rising, at_ceil;
  logic [W-1:0] ceil_val;
  logic [W-1:0] act   [NCH];
  logic         we    [NCH];
  logic [W-1:0] wdat  [NCH];
  logic [1:0]   mraw  [NCH];
  logic         fclr  [NCH];
  logic         wv    [NCH];
  logic         fl    [NCH];

  always_comb begin
    we[0] = cmp_a_we;  wdat[0] = cmp_a_in;  mraw[0] = mode_a;  fclr[0] = match_a_clr;
    we[1] = cmp_b_we;  wdat[1] = cmp_b_in;  mraw[1] = mode_b;  fclr[1] = match_b_clr;
    ceil_val = top_sel ? act[0] : FULL;
  end

  pwm_updown_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ceil_val (ceil_val),
    .ovf_clr  (ovf_clr),
    .cnt      (count),
    .rising   (rising),
    .at_ceil  (at_ceil),
    .ovf_flag (ovf_flag)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_cmp_channel #(.W(W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .reload   (at_ceil),
      .cnt      (count),
      .rising   (rising),
      .wr_en    (we[g]),
      .wr_val   (wdat[g]),
      .mode     (cmo_mode_e'(mraw[g])),
      .flag_clr (fclr[g]),
      .active   (act[g]),
      .wave     (wv[g]),
      .flag     (fl[g])
    );
  end

  assign wave_a       = wv[0];
  assign wave_b       = wv[1];
  assign match_a_flag = fl[0];
  assign match_b_flag = fl[1];

  // R3
  full_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && count == FULL) |=> (count == FULL - W'(1)));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count == '0) && !wave_a && !wave_b && !ovf_flag && !match_a_flag && !match_b_flag);

endmodule

// File: tb/tb_pwm_phase_correct.sv
module tb_pwm_phase_correct;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, top_sel = 1'b0;
  logic cmp_a_we = 1'b0, cmp_b_we = 1'b0;
  logic [7:0] cmp_a_in = '0, cmp_b_in = '0;
  logic [1:0] mode_a = 2'd0, mode_b = 2'd0;
  logic ovf_clr = 1'b0, match_a_clr = 1'b0, match_b_clr = 1'b0;
  logic [7:0] count;
  logic wave_a, wave_b, ovf_flag, match_a_flag, match_b_flag;

  int n_tests = 0, n_fail = 0;
  bit cmp_on = 1'b0;
  int peak;

  // reference model state
  int m_cnt = 0, m_bufa = 0, m_bufb = 0, m_acta = 0, m_actb = 0;
  bit m_up = 1, m_wa = 0, m_wb = 0, m_ovf = 0, m_fa = 0, m_fb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_phase_correct dut (
    .clk(clk), .rst(rst), .tick(tick), .top_sel(top_sel),
    .cmp_a_we(cmp_a_we), .cmp_a_in(cmp_a_in), .cmp_b_we(cmp_b_we), .cmp_b_in(cmp_b_in),
    .mode_a(mode_a), .mode_b(mode_b), .ovf_clr(ovf_clr),
    .match_a_clr(match_a_clr), .match_b_clr(match_b_clr),
    .count(count), .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
    .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
  );

  function automatic bit next_wave(bit cur, int mode, bit hit, bit up, bit tk);
    if (mode < 2) return 1'b0;                 // R7
    if (!(tk && hit)) return cur;              // R10
    return (mode == 3) ? up : !up;             // R5 / R6
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_up = 1; m_bufa = 0; m_bufb = 0; m_acta = 0; m_actb = 0;
      m_wa = 0; m_wb = 0; m_ovf = 0; m_fa = 0; m_fb = 0;
    end else begin
      int top, na, nb;
      bit ha, hb, turn, bot;
      top  = top_sel ? m_acta : 255;
      ha   = (m_cnt == m_acta);
      hb   = (m_cnt == m_actb);
      turn = m_up && (m_cnt >= top);
      bot  = !m_up && (m_cnt <= 1);
      m_wa = next_wave(m_wa, mode_a, ha, m_up, tick);
      m_wb = next_wave(m_wb, mode_b, hb, m_up, tick);
      if (tick && ha) m_fa = 1; else if (match_a_clr) m_fa = 0;
      if (tick && hb) m_fb = 1; else if (match_b_clr) m_fb = 0;
      if (tick && bot) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      na = m_acta; nb = m_actb;
      if (tick && turn) begin na = m_bufa; nb = m_bufb; end
      if (tick) begin
        if (turn) begin m_up = 0; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
        else if (m_up) m_cnt = m_cnt + 1;
        else if (bot) begin m_up = 1; m_cnt = 0; end
        else m_cnt = m_cnt - 1;
      end
      m_acta = na; m_actb = nb;
      if (cmp_a_we) m_bufa = cmp_a_in;
      if (cmp_b_we) m_bufb = cmp_b_in;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(count == m_cnt[7:0], "R2 count", count, m_cnt);
      chk(wave_a == m_wa, "R5/R6 wave_a", wave_a, m_wa);
      chk(wave_b == m_wb, "R5/R6/R7 wave_b", wave_b, m_wb);
      chk(ovf_flag == m_ovf, "R8 ovf_flag", ovf_flag, m_ovf);
      chk(match_a_flag == m_fa, "R9 match_a_flag", match_a_flag, m_fa);
      chk(match_b_flag == m_fb, "R9 match_b_flag", match_b_flag, m_fb);
    end
  end

  task automatic wr_a(int v);
    cmp_a_in = v[7:0]; cmp_a_we = 1'b1;
    @(negedge clk); cmp_a_we = 1'b0;
  endtask

  task automatic wr_b(int v);
    cmp_b_in = v[7:0]; cmp_b_we = 1'b1;
    @(negedge clk); cmp_b_we = 1'b0;
  endtask

  // run n cycles; strobe density 1/div; random clears; record peak count
  task automatic run(int n, int div);
    peak = 0;
    for (int i = 0; i < n; i++) begin
      tick        = ($urandom_range(div - 1) == 0);
      ovf_clr     = ($urandom_range(15) == 0);
      match_a_clr = ($urandom_range(15) == 0);
      match_b_clr = ($urandom_range(15) == 0);
      @(negedge clk);
      if (int'(count) > peak) peak = count;
    end
    ovf_clr = 0; match_a_clr = 0; match_b_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(count == 0 && !wave_a && !wave_b && !ovf_flag && !match_a_flag && !match_b_flag,
        "R1 reset", {count, wave_a, wave_b, ovf_flag}, 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    @(negedge clk);
    chk(count == 0, "R1 after reset", count, 0);

    // full-scale ceiling, non-inverting A / inverting B
    mode_a = 2'd2; mode_b = 2'd3;
    wr_a(100); wr_b(200);
    run(1200, 1);
    chk(peak == 255, "R3 full-scale peak", peak, 255);

    // ceiling from channel A
    top_sel = 1'b1;
    wr_a(60);
    run(600, 1);
    run(300, 1);
    chk(peak == 60, "R3 compare-A peak", peak, 60);

    // sparse strobes, inverting A, B off via code 1
    mode_a = 2'd3; mode_b = 2'd1; wr_b(30);
    run(1500, 3);

    // R10 no strobe: count frozen
    tick = 1'b0;
    @(negedge clk);
    begin
      int held;
      held = count;
      repeat (20) @(negedge clk);
      chk(int'(count) == held, "R10 count held without tick", count, held);
    end

    // R7 mode 0 forces B low
    mode_b = 2'd0;
    @(negedge clk);
    chk(wave_b == 1'b0, "R7 mode 0 low", wave_b, 0);

    // R4 double buffering: ceiling 40, write 80 mid-rise
    mode_a = 2'd2; mode_b = 2'd2;
    wr_a(40);
    run(200, 1);
    tick = 1'b1;
    while (!(count == 10 && dut.count == 10)) @(negedge clk);
    wr_a(80);
    run(60, 1);
    chk(peak == 40, "R4 old ceiling kept this period", peak, 40);
    run(200, 1);
    chk(peak == 80, "R4 new ceiling after reload", peak, 80);

    tick = 1'b0;
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule